// File: doc/BRIEF.md
# Framed Serial DAC Register Front End

This block is the digital side of a serial-input digital-to-analogue converter. A host writes 16-bit words over a slow serial link. The link has a data line, a bit clock, a frame-sync strobe and an optional active-low chip select. The block samples these lines with its own system clock. It marks the start of each word on a frame-sync falling edge and shifts in one bit, most significant first, on every falling edge of the bit clock. A word is committed when its sixteenth bit arrives. It is also committed early if frame sync rises after at least one bit has been received.

Each committed word carries four option bits in its top nibble. Bits 15 and 12 together form a two-bit target address. Bit 14 selects the fast or slow settling mode, and bit 13 requests power-down. The lower twelve bits are the payload. Address 00 loads the payload into the 12-bit converter code. Address 11 loads a 2-bit reference-source selection from payload bits 1..0. The other two addresses are reserved and change nothing.

Power-down never disturbs the stored code, so the output comes back at its old level when power-down is released. A one-cycle strobe marks every load of the converter code. When several converters share one link, each gets its own chip select. With a single converter, the chip select can be tied low and the link runs on three wires.

Top module: `dacfe_top`

## Requirements
- R1: While `rst` is high and after it is released, `dac_code`, `speed_fast`, `power_down`, `ref_sel` and `dac_update` are all zero until a word is committed.
- R2: While `ser_csn` is high, every edge on `ser_fs` and `ser_sclk` is ignored and no word is committed. With `ser_csn` held low across consecutive frames, each frame is received normally.
- R3: A falling edge on `ser_fs` clears the receiver and starts a word. On each falling edge of `ser_sclk`, `ser_din` is shifted in, with the first bit becoming bit 15.
- R4: On the 16th falling `ser_sclk` edge of a word, the word is committed. Its effect appears on the outputs at the (SYNC_STAGES+2)-th rising `clk` edge, counting the edge that first samples the line change as the first.
- R5: If `ser_fs` rises after N bits (1 ≤ N ≤ 15), the word is committed at once. The N received bits occupy bits N-1..0 in arrival order, and all higher bits are zero.
- R6: A committed word with bit15=0 and bit12=0 loads bits 11..0 into `dac_code`.
- R7: A committed word with bit15=1 and bit12=1 loads bits 1..0 into `ref_sel` and leaves `dac_code` unchanged. Bits 11..2 have no effect. The codes are 00 external, 01 internal 1.024 V, 10 internal 2.048 V and 11 external.
- R8: A committed word with bit15≠bit12 (reserved) changes no output.
- R9: Every committed word that is not reserved loads bit 14 into `speed_fast` (1 = fast settling) and bit 13 into `power_down` (1 = powered down).
- R10: Entering or leaving power-down never changes `dac_code`. After release, the code held before power-down is still present.
- R11: If `ser_csn` rises while a word is in progress, the word is discarded. A frame in which `ser_fs` rises with zero bits received commits nothing.
- R12: `dac_update` is high for exactly one `clk` cycle, in the cycle in which `dac_code` takes a newly written value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| ser_din | input | 1 | Serial data line |
| ser_sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_fs | input | 1 | Frame sync; falling edge starts a word, rising edge ends it early |
| ser_csn | input | 1 | Active-low chip select; tie low for three-wire use |
| dac_code | output | 12 | Stored converter code |
| speed_fast | output | 1 | 1 = fast settling, 0 = slow settling |
| power_down | output | 1 | 1 = power-down requested |
| ref_sel | output | 2 | Reference-source selection code |
| dac_update | output | 1 | One-cycle strobe on every converter-code load |

## Verification
Some properties are checked on every clock:
- the bit counter never passes a full word;
- a commit only comes out of an open frame, and the frame closes with it;
- reserved addresses leave every output register unchanged;
- the converter code holds steady in any cycle without the update strobe;
- the strobe follows a commit and never lasts two cycles.

Other behaviour needs whole frames, and only the bench scenarios show it:
- the most-significant-first bit order;
- the exact commit latency;
- right alignment of a word cut short by frame sync;
- discarding on a chip-select abort;
- blindness to the link while deselected;
- restoring the earlier code after power-down.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Target decoded from {word[15], word[12]}
  typedef enum logic [1:0] {
    TGT_DAC   = 2'b00,
    TGT_RSV_A = 2'b01,
    TGT_RSV_B = 2'b10,
    TGT_CTRL  = 2'b11
  } target_e;

  // Converter operating mode carried by every non-reserved word
  typedef struct packed {
    logic fast;
    logic sleep;
  } mode_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  // Idle level of every serial line is high, so reset to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din_s,
  input  logic               sclk_s,
  input  logic               fs_s,
  input  logic               csn_s,
  output logic               commit_o,
  output logic [FRAME_W-1:0] word_o
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               sclk_p, fs_p;
  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               commit_q;
  logic [FRAME_W-1:0] word_q;

  logic enabled, sclk_fall, fs_fall, fs_rise;
  logic [FRAME_W-1:0] shifted;

  assign enabled   = ~csn_s;
  assign sclk_fall = sclk_p & ~sclk_s;
  assign fs_fall   = fs_p & ~fs_s;
  assign fs_rise   = ~fs_p & fs_s;
  assign shifted   = {shreg_q[FRAME_W-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b1;
      fs_p   <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      fs_p   <= fs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      commit_q <= 1'b0;
      if (!enabled) begin
        active_q <= 1'b0;                 // deselect discards any open word
      end else if (fs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        shreg_q  <= '0;
      end else if (active_q && fs_rise) begin
        active_q <= 1'b0;
        if (cnt_q != '0) begin
          commit_q <= 1'b1;
          word_q   <= shreg_q;
        end
      end else if (active_q && sclk_fall) begin
        shreg_q <= shifted;
        if (cnt_q == LAST_BIT) begin
          commit_q <= 1'b1;
          word_q   <= shifted;
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign commit_o = commit_q;
  assign word_o   = word_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(FRAME_W));

  // R11
  commit_from_open_chk: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> $past(active_q));

  // R4
  commit_closes_chk: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> !active_q);

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [DATA_W-1:0]  dac_o,
  output logic               fast_o,
  output logic               sleep_o,
  output logic [1:0]         ref_o,
  output logic               upd_o
);

  localparam int ADDR_HI = FRAME_W - 1;
  localparam int FAST_B  = FRAME_W - 2;
  localparam int SLEEP_B = FRAME_W - 3;
  localparam int ADDR_LO = FRAME_W - 4;

  target_e           tgt;
  mode_t             mode_q;
  logic [DATA_W-1:0] dac_q;
  logic [1:0]        ref_q;
  logic              upd_q;

  assign tgt = target_e'({word_i[ADDR_HI], word_i[ADDR_LO]});

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q  <= '0;
      ref_q  <= '0;
      mode_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (commit_i) begin
        unique case (tgt)
          TGT_DAC: begin
            dac_q       <= word_i[DATA_W-1:0];
            upd_q       <= 1'b1;
            mode_q.fast  <= word_i[FAST_B];
            mode_q.sleep <= word_i[SLEEP_B];
          end
          TGT_CTRL: begin
            ref_q        <= word_i[1:0];
            mode_q.fast  <= word_i[FAST_B];
            mode_q.sleep <= word_i[SLEEP_B];
          end
          default: ;
        endcase
      end
    end
  end

  assign dac_o   = dac_q;
  assign fast_o  = mode_q.fast;
  assign sleep_o = mode_q.sleep;
  assign ref_o   = ref_q;
  assign upd_o   = upd_q;

  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && (tgt == TGT_RSV_A || tgt == TGT_RSV_B))
      |=> ($stable(dac_q) && $stable(ref_q) && $stable(mode_q)));

  // R10
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_q |-> $stable(dac_q));

  // R12
  upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> $past(commit_i));

  // R12
  upd_single_chk: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> !upd_q);

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  input  logic              ser_sclk,
  input  logic              ser_fs,
  input  logic              ser_csn,
  output logic [DATA_W-1:0] dac_code,
  output logic              speed_fast,
  output logic              power_down,
  output logic [1:0]        ref_sel,
  output logic              dac_update
);

  localparam int FRAME_W = DATA_W + 4;

  logic [3:0]         lines_s;
  logic               commit;
  logic [FRAME_W-1:0] word;

  dacfe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_din, ser_sclk, ser_fs, ser_csn}),
    .q   (lines_s)
  );

  dacfe_rx #(.FRAME_W(FRAME_W)) i_rx (
    .clk      (clk),
    .rst      (rst),
    .din_s    (lines_s[3]),
    .sclk_s   (lines_s[2]),
    .fs_s     (lines_s[1]),
    .csn_s    (lines_s[0]),
    .commit_o (commit),
    .word_o   (word)
  );

  dacfe_regs #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .word_i   (word),
    .dac_o    (dac_code),
    .fast_o   (speed_fast),
    .sleep_o  (power_down),
    .ref_o    (ref_sel),
    .upd_o    (dac_update)
  );

endmodule

// File: tb/test_dacfe_top.sv
module test_dacfe_top;
  localparam int SYNC = 2;
  localparam int HALF = 3;
  localparam int LAT  = SYNC + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic din = 1'b1, sclk = 1'b1, fs = 1'b1, csn = 1'b1;
  logic [11:0] dac_code;
  logic speed_fast, power_down, dac_update;
  logic [1:0] ref_sel;

  int checks = 0, fails = 0, cyc = 0, n_upd = 0;
  bit done = 0;

  int          due_q[$];
  logic [15:0] word_q[$];

  logic [11:0] m_dac = '0;
  logic [1:0]  m_ref = '0;
  logic        m_spd = 0, m_pwr = 0, m_upd = 0;

  dacfe_top #(.DATA_W(12), .SYNC_STAGES(SYNC)) i_dacfe_top (
    .clk(clk), .rst(rst), .ser_din(din), .ser_sclk(sclk), .ser_fs(fs),
    .ser_csn(csn), .dac_code(dac_code), .speed_fast(speed_fast),
    .power_down(power_down), .ref_sel(ref_sel), .dac_update(dac_update));

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] w);
    case ({w[15], w[12]})
      2'b00: begin m_dac = w[11:0]; m_upd = 1; m_spd = w[14]; m_pwr = w[13]; end
      2'b11: begin m_ref = w[1:0]; m_spd = w[14]; m_pwr = w[13]; end
      default: ;
    endcase
  endtask

  // Per-cycle reference comparison (R4 latency, R12 strobe timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      m_upd = 0;
      while (due_q.size() > 0 && due_q[0] == cyc) begin
        apply(word_q[0]);
        void'(due_q.pop_front());
        void'(word_q.pop_front());
      end
      if (dac_update) n_upd++;
      chk("R4 dac_code per-cycle", dac_code, m_dac);
      chk("R9 speed_fast per-cycle", speed_fast, m_spd);
      chk("R9 power_down per-cycle", power_down, m_pwr);
      chk("R7 ref_sel per-cycle", ref_sel, m_ref);
      chk("R12 dac_update per-cycle", dac_update, m_upd);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [15:0] w);
    due_q.push_back(cyc + LAT);
    word_q.push_back(w);
  endtask

  // nbits: bits sent; abort: raise csn mid-word; keep_cs: leave csn low;
  // cs_off: run the whole frame with csn high
  task automatic frame(logic [15:0] w, int nbits, bit abort, bit keep_cs, bit cs_off);
    logic [15:0] acc = '0;
    @(negedge clk);
    csn = cs_off;
    tick(HALF);
    fs = 0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = w[15-i];
      tick(HALF);
      sclk = 0;
      acc = {acc[14:0], w[15-i]};
      if (i == 15 && !cs_off) push(acc);
      tick(HALF);
      sclk = 1;
    end
    if (abort) begin
      csn = 1;
      tick(HALF);
      fs = 1;
      tick(HALF);
    end else begin
      fs = 1;
      if (nbits > 0 && nbits < 16 && !cs_off) push(acc);
      tick(HALF);
      if (!keep_cs) csn = 1;
      tick(HALF);
    end
    tick(2);
  endtask

  initial begin
    tick(5);
    // R1 reset state while reset is held
    chk("R1 dac_code in reset", dac_code, 0);
    chk("R1 dac_update in reset", dac_update, 0);
    rst = 0;
    tick(3);
    chk("R1 dac_code", dac_code, 0);
    chk("R1 speed_fast", speed_fast, 0);
    chk("R1 power_down", power_down, 0);
    chk("R1 ref_sel", ref_sel, 0);

    // R3 R6 R9: DAC write, fast mode
    frame(16'h4A5C, 16, 0, 0, 0);
    chk("R3/R6 dac_code", dac_code, 12'hA5C);
    chk("R9 speed_fast", speed_fast, 1);
    chk("R9 power_down", power_down, 0);

    // R7: control write, ref=10, junk in D11..D2
    frame(16'h9FF6, 16, 0, 0, 0);
    chk("R7 ref_sel", ref_sel, 2);
    chk("R7 dac_code kept", dac_code, 12'hA5C);
    chk("R9 speed_fast from ctrl", speed_fast, 0);

    // R8: reserved addresses 01 and 10
    frame(16'h5123, 16, 0, 0, 0);
    frame(16'hE456, 16, 0, 0, 0);
    chk("R8 dac_code", dac_code, 12'hA5C);
    chk("R8 ref_sel", ref_sel, 2);
    chk("R8 speed_fast", speed_fast, 0);
    chk("R8 power_down", power_down, 0);

    // R10: power-down via control, then release
    frame(16'hB001, 16, 0, 0, 0);
    chk("R10 power_down set", power_down, 1);
    chk("R10 dac_code held", dac_code, 12'hA5C);
    chk("R7 ref_sel 01", ref_sel, 1);
    frame(16'h9003, 16, 0, 0, 0);
    chk("R10 power_down released", power_down, 0);
    chk("R10 dac_code restored", dac_code, 12'hA5C);

    // R5: early end after 10 bits
    frame(16'hD680, 10, 0, 0, 0);
    chk("R5 dac_code right aligned", dac_code, 12'h35A);
    chk("R5 speed_fast", speed_fast, 0);

    // R11: abort by chip select, and zero-bit frame
    frame(16'h0FFF, 7, 1, 0, 0);
    chk("R11 abort dac_code", dac_code, 12'h35A);
    frame(16'h0000, 0, 0, 0, 0);
    chk("R11 empty frame dac_code", dac_code, 12'h35A);

    // R2: full frame while deselected
    frame(16'h0123, 16, 0, 0, 1);
    chk("R2 deselected dac_code", dac_code, 12'h35A);

    // R2: three-wire use, csn low across two frames
    frame(16'h0777, 16, 0, 1, 0);
    chk("R2 three-wire first", dac_code, 12'h777);
    frame(16'h4888, 16, 0, 0, 0);
    chk("R2 three-wire second", dac_code, 12'h888);
    chk("R9 speed_fast three-wire", speed_fast, 1);

    // R9 R10: DAC write with power-down, release via control
    frame(16'h2ABC, 16, 0, 0, 0);
    chk("R9 power_down from dac write", power_down, 1);
    chk("R6 dac_code", dac_code, 12'hABC);
    frame(16'h9002, 16, 0, 0, 0);
    chk("R10 dac_code after release", dac_code, 12'hABC);
    chk("R10 power_down", power_down, 0);

    tick(4);
    chk("R12 update strobe count", n_upd, 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule